// File: doc/BRIEF.md
# Obfuscating Shift-Register Key Register

This block is a single byte-wide register location on a small parallel bus. It answers reads with a byte that changes over time, so software can run a challenge and response against it. Each of the eight bit lanes holds its own short shift register. The length of each lane and the polarity of its output are fixed at elaboration. A read returns the output stage of every lane after polarity is applied.

A write loads an eight-bit data register. Shifting happens only when bit 0 of that register goes from 0 to 1. On that event all lanes advance one position together. Each lane takes in its data-register bit XOR its own current read value. Because of this, the byte sequence seen on reads depends on the whole history of writes. Reads never disturb any state.

Decoding uses seven chip-select inputs: four active high and three active low. A bus-phase qualifier and a read/not-write strobe complete the access decode.

Top module: `keyreg_top`

## Requirements
- R1: The block is selected only when all four `cs_act_hi` bits are 1 and all three `cs_act_lo_n` bits are 0. Any other combination blocks both reads and writes.
- R2: A write is taken when the block is selected, `bus_phase` is 1 and `rd_not_wr` is 0. The data register takes `wdata` at that clock edge.
- R3: During a read cycle (selected, `bus_phase` 1, `rd_not_wr` 1), `rdata_oe` is 1 and `rdata` carries the read value. At all other times `rdata_oe` is 0 and `rdata` is 0.
- R4: Bit i of the read value is the last active cell of lane i XOR bit i of parameter `OUT_INV`.
- R5: When data-register bit 0 has gone from 0 to 1 at a clock edge, every lane shifts by exactly one position at the next clock edge. One such change produces exactly one shift.
- R6: On a shift, the value entering lane i is data-register bit i XOR bit i of the read value held just before that edge.
- R7: Lane i has the length given by nibble i (bits 4i+3..4i) of parameter `LANE_LEN`, which must be 1 to 8. A value that enters a lane reaches its output after that many shifts.
- R8: While `rst` is high at a clock edge, all cells are cleared and every data-register bit is set to 1. The first cycles after reset therefore produce no shift, and the read value equals `OUT_INV`.
- R9: Reads, unselected accesses and accesses with `bus_phase` 0 change neither the data register nor any lane.
- R10: A write that leaves bit 0 at 1, or that clears it, causes no shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_act_hi | input | 4 | Chip selects, all must be 1 |
| cs_act_lo_n | input | 3 | Chip selects, all must be 0 |
| bus_phase | input | 1 | Bus data-phase qualifier, access valid when 1 |
| rd_not_wr | input | 1 | 1 = read, 0 = write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not driven |
| rdata_oe | output | 1 | Read-data output enable |

## Verification
The assertions assume the bus inputs stay stable between clock edges. They also assume that reset is held for at least one edge before any access. The bench changes every input once per cycle, just after the rising edge, and starts with reset held for several cycles.

Under those assumptions, the data register can change only on a write cycle. A shift can only follow one. Stimulus covers:
- select patterns with each select line wrong in turn;
- writes with the phase qualifier low;
- writes that hold bit 0 high or clear it;
- back-to-back toggles of bit 0;
- a long run of random accesses checked against a queue-based model.

// File: rtl/keyreg_pkg.sv
package keyreg_pkg;
  localparam int NLANES = 8;
  localparam int MAXLEN = 8;

  function automatic int lane_len(input logic [4*NLANES-1:0] lens, input int idx);
    return int'(lens[4*idx +: 4]);
  endfunction
endpackage

// File: rtl/keyreg_decode.sv
module keyreg_decode #(
  parameter int NHI = 4,
  parameter int NLO = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NHI-1:0] cs_act_hi,
  input  logic [NLO-1:0] cs_act_lo_n,
  input  logic           bus_phase,
  input  logic           rd_not_wr,
  output logic           wr_en,
  output logic           rd_en
);
  logic sel;

  assign sel   = (&cs_act_hi) & ~(|cs_act_lo_n);
  assign wr_en = sel & bus_phase & ~rd_not_wr;
  assign rd_en = sel & bus_phase & rd_not_wr;

  // R2/R3: a single cycle cannot be both a read and a write
  p_rw_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_en));
  // R1: any select line off means no access at all
  p_desel_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (!(&cs_act_hi) || (|cs_act_lo_n)) |-> !(wr_en || rd_en));
endmodule

// File: rtl/keyreg_trig.sv
module keyreg_trig #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dreg,
  output logic         shift_en
);
  logic d0_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      dreg    <= '1;
      d0_prev <= 1'b1;
    end else begin
      d0_prev <= dreg[0];
      if (wr_en) dreg <= wdata;
    end
  end

  assign shift_en = dreg[0] & ~d0_prev;

  // R9: data register holds unless a write is accepted
  p_hold_no_write_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(dreg));
  // R5: one shift pulse per rising edge of bit 0
  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> !shift_en);
  // R5/R10: a shift pulse always follows an accepted write
  p_pulse_after_write_r5: assert property (@(posedge clk) disable iff (rst)
    shift_en |-> $past(wr_en));
endmodule

// File: rtl/keyreg_lane.sv
module keyreg_lane #(
  parameter int   LEN = 4,
  parameter logic INV = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic din,
  output logic q
);
  logic [LEN-1:0] cells;

  generate
    if (LEN == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst)           cells <= '0;
        else if (shift_en) cells <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst)           cells <= '0;
        else if (shift_en) cells <= {cells[LEN-2:0], din};
      end
    end
  endgenerate

  assign q = cells[LEN-1] ^ INV;

  // R9/R10: cells hold when there is no shift
  p_hold_no_shift_r10: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(cells));
  // R6: the value presented at the shift edge lands in the first cell
  p_entry_cell_r6: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> cells[0] == $past(din));
endmodule

// File: rtl/keyreg_top.sv
module keyreg_top
  import keyreg_pkg::*;
#(
  parameter logic [4*NLANES-1:0] LANE_LEN = 32'h1647_2853,
  parameter logic [NLANES-1:0]   OUT_INV  = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        cs_act_hi,
  input  logic [2:0]        cs_act_lo_n,
  input  logic              bus_phase,
  input  logic              rd_not_wr,
  input  logic [NLANES-1:0] wdata,
  output logic [NLANES-1:0] rdata,
  output logic              rdata_oe
);
  logic              wr_en, rd_en, shift_en;
  logic [NLANES-1:0] dreg, rval, fb;

  keyreg_decode #(.NHI(4), .NLO(3)) u_dec (
    .clk(clk), .rst(rst), .cs_act_hi(cs_act_hi), .cs_act_lo_n(cs_act_lo_n),
    .bus_phase(bus_phase), .rd_not_wr(rd_not_wr),
    .wr_en(wr_en), .rd_en(rd_en)
  );

  keyreg_trig #(.W(NLANES)) u_trig (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata),
    .dreg(dreg), .shift_en(shift_en)
  );

  assign fb = dreg ^ rval;

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    keyreg_lane #(.LEN(lane_len(LANE_LEN, i)), .INV(OUT_INV[i])) u_lane (
      .clk(clk), .rst(rst), .shift_en(shift_en), .din(fb[i]), .q(rval[i])
    );
  end

  assign rdata_oe = rd_en;
  assign rdata    = rd_en ? rval : '0;

  // R9: a read cycle never disturbs the read value
  p_read_no_change_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !shift_en) |=> $stable(rval));
  // R3: bus released whenever not reading
  p_bus_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !rdata_oe |-> rdata == '0);
endmodule

// File: tb/tb_keyreg_top.sv
module tb_keyreg_top;
  localparam logic [31:0] LENS = 32'h1647_2853;
  localparam logic [7:0]  INV  = 8'hA5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cs_hi = 4'h0;
  logic [2:0] cs_lo_n = 3'h7;
  logic       phase = 1'b0;
  logic       rnw = 1'b1;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rdata_oe;

  keyreg_top #(.LANE_LEN(LENS), .OUT_INV(INV)) dut (
    .clk(clk), .rst(rst), .cs_act_hi(cs_hi), .cs_act_lo_n(cs_lo_n),
    .bus_phase(phase), .rd_not_wr(rnw), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  always #2 clk = ~clk;

  int    compared = 0;
  int    mismatched = 0;
  bit    done = 0;
  string cur_req = "R8";

  // behavioural reference model
  bit       mq[8][$];
  bit [7:0] m_dreg;
  bit       m_prev;

  function automatic bit [7:0] m_read();
    bit [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = mq[i][mq[i].size()-1] ^ INV[i];
    return v;
  endfunction

  function automatic bit m_sel();
    return (cs_hi == 4'hF) && (cs_lo_n == 3'h0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) begin
        mq[i].delete();
        for (int k = 0; k < int'(LENS[4*i +: 4]); k++) mq[i].push_back(1'b0);
      end
      m_dreg = 8'hFF;
      m_prev = 1'b1;
    end else begin
      bit [7:0] rv;
      bit       sh;
      sh = m_dreg[0] && !m_prev;
      rv = m_read();
      if (sh) begin
        for (int i = 0; i < 8; i++) begin
          mq[i].push_front(m_dreg[i] ^ rv[i]);
          void'(mq[i].pop_back());
        end
      end
      m_prev = m_dreg[0];
      if (m_sel() && phase && !rnw) m_dreg = wdata;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      bit       eoe;
      bit [7:0] eout;
      eoe  = m_sel() && phase && rnw;
      eout = eoe ? m_read() : 8'h00;
      compared++;
      if (rdata_oe !== eoe || rdata !== eout) begin
        mismatched++;
        $display("FAIL %s: got oe=%0b data=%02h, expected oe=%0b data=%02h",
                 cur_req, rdata_oe, rdata, eoe, eout);
      end
    end
  end

  task automatic bus(input logic [3:0] h, input logic [2:0] l, input logic p,
                     input logic rw, input logic [7:0] d);
    @(posedge clk); #1;
    cs_hi = h; cs_lo_n = l; phase = p; rnw = rw; wdata = d;
  endtask

  task automatic rd();
    bus(4'hF, 3'h0, 1'b1, 1'b1, 8'h00);
  endtask

  task automatic wr(input logic [7:0] d);
    bus(4'hF, 3'h0, 1'b1, 1'b0, d);
  endtask

  task automatic idle();
    bus(4'h0, 3'h7, 1'b0, 1'b1, 8'h00);
  endtask

  task automatic pulse(input logic [7:0] d);
    wr(d & 8'hFE); idle(); wr(d | 8'h01); idle(); rd(); rd();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    // R8: reset state read directly
    cur_req = "R8";
    rd(); @(negedge clk);
    compared++;
    if (rdata !== INV || rdata_oe !== 1'b1) begin
      mismatched++;
      $display("FAIL R8: got %02h expected %02h", rdata, INV);
    end
    rd(); rd();
    // R1: each select line wrong in turn
    cur_req = "R1";
    for (int b = 0; b < 4; b++) begin
      bus(4'hF & ~(4'h1 << b), 3'h0, 1'b1, 1'b1, 8'h00);
      bus(4'hF & ~(4'h1 << b), 3'h0, 1'b1, 1'b0, 8'h00);
    end
    for (int b = 0; b < 3; b++) begin
      bus(4'hF, 3'h1 << b, 1'b1, 1'b1, 8'h00);
      bus(4'hF, 3'h1 << b, 1'b1, 1'b0, 8'h00);
    end
    rd();
    // R2/R9: phase low blocks a write
    cur_req = "R9";
    bus(4'hF, 3'h0, 1'b0, 1'b0, 8'h00); idle();
    bus(4'hF, 3'h0, 1'b0, 1'b0, 8'h01); rd(); rd();
    // R5/R6/R7/R4: shifts with varied data
    cur_req = "R5";
    pulse(8'h00);
    cur_req = "R6";
    pulse(8'hFF); pulse(8'h3C); pulse(8'hA5);
    cur_req = "R7";
    for (int k = 0; k < 10; k++) pulse(8'(k * 37));
    // R10: bit 0 held at 1 or cleared: no shift
    cur_req = "R10";
    wr(8'h81); rd(); wr(8'hC3); rd(); wr(8'h40); rd(); wr(8'h02); rd(); rd();
    // R5: back-to-back toggles of bit 0
    cur_req = "R5";
    for (int k = 0; k < 6; k++) begin wr(8'h10); wr(8'h11); end
    rd(); rd(); rd();
    // R2/R3/R4: random mix
    cur_req = "R4";
    for (int k = 0; k < 3000; k++) begin
      int unsigned r = $urandom;
      if (r[3:0] == 4'h0)
        bus(4'(r >> 4), 3'(r >> 8), r[11], r[12], 8'(r >> 16));
      else if (r[4])
        wr(8'(r >> 16));
      else
        rd();
    end
    // R8: reset mid-stream
    cur_req = "R8";
    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    rd(); rd(); pulse(8'h5A); rd();
    cur_req = "R3";
    idle(); idle();
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule